// File: doc/BRIEF.md
# Magic-Sequence Watchdog Timer

This block is a memory-mapped watchdog. Once armed, a free-running counter measures a window of a power-of-two number of clock cycles, and software must service the block before that window ends. Servicing takes two stores: a fixed 32-bit key to the first service register, and a second fixed key to the second service register as the very next write. If the window runs out, or either store is wrong, the block raises a one-cycle reset request toward the system reset network.

Every reset request records a 3-bit cause code. The code lives in a register that only the hard reset input clears. Request-driven resets clear the configuration, the counter and the service sequencer, but keep the code, so boot software can read why the last reset happened. A software-triggered reset register and a user reset input pin are two further sources of the request.

Top module: `wdt_magic`

## Requirements
- R1: While `rst_n` is low, and after it is released, the configuration reads 0, the cause code reads 0 (hard reset), and `rst_req` is low.
- R2: Registers are decoded at word-aligned byte addresses; a misaligned address reads 0 and writes nothing. 0x00 is soft reset, 0x04 is configuration (bit 31 enable, bits [4:0] delay, all other bits read 0), 0x08 is service-1 (read: cause code in bits [2:0]) and 0x0C is service-2. Reads are combinational from `addr`.
- R3: While enabled, `rst_req` pulses exactly 2^(delay+1) cycles after the write edge that set enable from 0, or after the last valid service. Rewriting enable=1 while already enabled does not restart the window. The cause code becomes 1.
- R4: A valid service is 0xABCD1234 written to 0x08, followed by 0x4321DCBA written to 0x0C as the next write. It restarts the window.
- R5: While enabled, any of the following makes `rst_req` pulse in the cycle after that write edge and sets the cause code to 2: a wrong value at 0x08, a wrong value at 0x0C, or a write to 0x0C that is not the next write after a correct 0x08 write. While disabled, these writes have no effect.
- R6: Writing enable=0 while enabled leaves the watchdog running and the configuration reading enabled. It stops only when a valid service completes.
- R7: Writing 0x00 with bit 0 set pulses `rst_req` in the next cycle and sets the cause code to 3. Writing it with bit 0 clear has no effect.
- R8: A rising edge on `user_rst` pulses `rst_req` in the next cycle and sets the cause code to 4. Holding the pin high yields a single pulse.
- R9: `rst_req` is high for exactly one cycle per event, and events are ignored during that cycle. Each pulse clears enable, delay, counter and service state, but not the cause code.
- R10: When events coincide, the cause code follows the priority soft reset (3) > bad service (2) > timeout (1) > user (4), and only one pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog counting clock |
| rst_n | input | 1 | Active-low hard reset, clears cause code |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte address of register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| user_rst | input | 1 | User reset request pin, rising-edge sensitive |
| rst_req | output | 1 | One-cycle reset request to the system |

## Verification
Every reset source becomes visible one register later: a soft-reset write, a bad service store or a user pin edge raises `rst_req` in the cycle after the clock edge that sampled it. A timeout arrives exactly 2^(delay+1) edges after the enabling write or the last valid service edge. Before each stimulus, the driver records the number of the edge that will take it, and pushes the cycle in which the pulse is due into a queue. A monitor on the falling edge pops the queue on each pulse and compares cycle numbers, so any early, late, missing or spurious pulse is reported. Register values, including the cause code, are combinational and are read between edges after the queue has drained.

// File: rtl/wdt_magic_pkg.sv
package wdt_magic_pkg;

  typedef enum logic [2:0] {
    CAUSE_HARD    = 3'd0,
    CAUSE_TIMEOUT = 3'd1,
    CAUSE_BADSVC  = 3'd2,
    CAUSE_SOFT    = 3'd3,
    CAUSE_USER    = 3'd4
  } cause_e;

  typedef enum logic [1:0] {
    SEL_SOFT = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_SVC1 = 2'd2,
    SEL_SVC2 = 2'd3
  } reg_sel_e;

  localparam logic [31:0] SVC_KEY_A = 32'hABCD_1234;
  localparam logic [31:0] SVC_KEY_B = 32'h4321_DCBA;

endpackage

// File: rtl/wdt_magic_cfg.sv
module wdt_magic_cfg #(
  parameter int DELAY_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               warm_clr,
  input  logic               cfg_wr,
  input  logic               wr_enable,
  input  logic [DELAY_W-1:0] wr_delay,
  input  logic               good_svc,
  output logic               en,
  output logic [DELAY_W-1:0] delay,
  output logic               start
);

  logic en_q;
  logic stop_pend_q;
  logic [DELAY_W-1:0] delay_q;

  // enable going 0 -> 1 restarts the window
  assign start = cfg_wr && wr_enable && !en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= 1'b0;
      stop_pend_q <= 1'b0;
      delay_q     <= '0;
    end else if (warm_clr) begin
      en_q        <= 1'b0;
      stop_pend_q <= 1'b0;
      delay_q     <= '0;
    end else if (cfg_wr) begin
      delay_q <= wr_delay;
      if (wr_enable) begin
        en_q        <= 1'b1;
        stop_pend_q <= 1'b0;
      end else if (en_q) begin
        stop_pend_q <= 1'b1;
      end
    end else if (good_svc && stop_pend_q) begin
      en_q        <= 1'b0;
      stop_pend_q <= 1'b0;
    end
  end

  assign en    = en_q;
  assign delay = delay_q;

  // R6: enable only drops on a completed service or a request-driven clear
  a_r6_stop_on_service: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> $past(good_svc || warm_clr));

endmodule

// File: rtl/wdt_magic_svc.sv
module wdt_magic_svc
  import wdt_magic_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_clr,
  input  logic              wr,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              en,
  output logic              good_svc,
  output logic              bad_svc
);

  logic armed_q;
  logic hit_a, hit_b, key_a_ok, key_b_ok;

  assign hit_a    = wr && (sel == SEL_SVC1);
  assign hit_b    = wr && (sel == SEL_SVC2);
  assign key_a_ok = (wdata == DATA_W'(SVC_KEY_A));
  assign key_b_ok = (wdata == DATA_W'(SVC_KEY_B));

  assign good_svc = hit_b && armed_q && key_b_ok;
  assign bad_svc  = en && ((hit_a && !key_a_ok) || (hit_b && !(armed_q && key_b_ok)));

  // armed only if the most recent write was a correct first key
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (warm_clr) armed_q <= 1'b0;
    else if (wr)       armed_q <= hit_a && key_a_ok;
  end

  // R4: a store is never both a valid and a bad service
  a_r4_svc_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(good_svc && bad_svc));

endmodule

// File: rtl/wdt_magic_cnt.sv
module wdt_magic_cnt #(
  parameter int DELAY_W = 5,
  parameter int CNT_W   = 1 << DELAY_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               warm_clr,
  input  logic               reload,
  input  logic               en,
  input  logic [DELAY_W-1:0] delay,
  output logic               expire
);

  logic [CNT_W-1:0] cnt_q;

  // last count of a 2^(d+1)-cycle window
  function automatic logic [CNT_W-1:0] last_count(input logic [DELAY_W-1:0] d);
    logic [CNT_W:0] span;
    span = {{CNT_W{1'b0}}, 1'b1} << (int'(d) + 1);
    return span[CNT_W-1:0] - {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  assign expire = en && (cnt_q == last_count(delay));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (warm_clr || reload) cnt_q <= '0;
    else if (en)                 cnt_q <= cnt_q + 1'b1;
  end

  // R4: a restart leaves the counter at zero
  a_r4_reload_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt_q == '0));

  // R3: expiry is a single-cycle event
  a_r3_expire_once: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);

endmodule

// File: rtl/wdt_magic_cause.sv
module wdt_magic_cause
  import wdt_magic_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   soft_evt,
  input  logic   bad_svc,
  input  logic   expire,
  input  logic   user_rst,
  output logic   warm_clr,
  output logic   rst_req,
  output cause_e cause
);

  logic   user_q, user_evt, any_evt, req_q;
  cause_e cause_q, cause_nxt;

  assign user_evt = user_rst && !user_q;
  assign any_evt  = !req_q && (soft_evt || bad_svc || expire || user_evt);

  always_comb begin
    if (soft_evt)     cause_nxt = CAUSE_SOFT;
    else if (bad_svc) cause_nxt = CAUSE_BADSVC;
    else if (expire)  cause_nxt = CAUSE_TIMEOUT;
    else              cause_nxt = CAUSE_USER;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      user_q  <= 1'b0;
      req_q   <= 1'b0;
      cause_q <= CAUSE_HARD;
    end else begin
      user_q <= user_rst;
      req_q  <= any_evt;
      if (any_evt) cause_q <= cause_nxt;
    end
  end

  assign warm_clr = any_evt;
  assign rst_req  = req_q;
  assign cause    = cause_q;

  // R9: request is a one-cycle pulse
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);

  // R7: soft reset wins and records code 3
  a_r7_soft_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_evt && !req_q) |=> (req_q && cause_q == CAUSE_SOFT));

  // R5: bad service records code 2
  a_r5_bad_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_svc && !soft_evt && !req_q) |=> (req_q && cause_q == CAUSE_BADSVC));

endmodule

// File: rtl/wdt_magic.sv
module wdt_magic
  import wdt_magic_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DELAY_W = 5,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              user_rst,
  output logic              rst_req
);

  localparam int CNT_W  = 1 << DELAY_W;
  localparam int EN_BIT = DATA_W - 1;

  reg_sel_e           sel;
  logic               aligned, wr;
  logic               cfg_wr, soft_evt;
  logic               en, start, good_svc, bad_svc, expire, warm_clr;
  logic [DELAY_W-1:0] delay;
  cause_e             cause;

  assign aligned  = (addr[1:0] == 2'b00);
  assign sel      = reg_sel_e'(addr[3:2]);
  assign wr       = wr_en && aligned;
  assign cfg_wr   = wr && (sel == SEL_CFG);
  assign soft_evt = wr && (sel == SEL_SOFT) && wdata[0];

  wdt_magic_cfg #(.DELAY_W(DELAY_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .warm_clr(warm_clr), .cfg_wr(cfg_wr),
    .wr_enable(wdata[EN_BIT]), .wr_delay(wdata[DELAY_W-1:0]),
    .good_svc(good_svc), .en(en), .delay(delay), .start(start)
  );

  wdt_magic_svc #(.DATA_W(DATA_W)) u_svc (
    .clk(clk), .rst_n(rst_n), .warm_clr(warm_clr), .wr(wr), .sel(sel),
    .wdata(wdata), .en(en), .good_svc(good_svc), .bad_svc(bad_svc)
  );

  wdt_magic_cnt #(.DELAY_W(DELAY_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .warm_clr(warm_clr), .reload(start || good_svc),
    .en(en), .delay(delay), .expire(expire)
  );

  wdt_magic_cause u_cause (
    .clk(clk), .rst_n(rst_n), .soft_evt(soft_evt), .bad_svc(bad_svc),
    .expire(expire), .user_rst(user_rst), .warm_clr(warm_clr),
    .rst_req(rst_req), .cause(cause)
  );

  always_comb begin
    rdata = '0;
    if (aligned) begin
      unique case (sel)
        SEL_CFG:  rdata = {en, {(DATA_W-1-DELAY_W){1'b0}}, delay};
        SEL_SVC1: rdata = {{(DATA_W-3){1'b0}}, cause};
        default:  rdata = '0;
      endcase
    end
  end

endmodule

// File: tb/wdt_magic_tb.sv
module wdt_magic_tb;

  localparam logic [31:0] KA = 32'hABCD_1234;
  localparam logic [31:0] KB = 32'h4321_DCBA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic user_rst = 1'b0;
  logic rst_req;

  always #4 clk = ~clk;

  wdt_magic u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .user_rst(user_rst), .rst_req(rst_req)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int due; string tag; } exp_t;
  exp_t sb[$];
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: every pulse must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && rst_req) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected rst_req pulse", cyc, -1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(cyc == e.due, e.tag, cyc, e.due);
      end
    end
  end

  task automatic expect_rst(input int due, input string tag);
    exp_t e;
    e.due = due;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d, output int edge_no);
    wr_en = 1'b1; addr = a; wdata = d;
    edge_no = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    check(rdata == exp, tag, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic service(output int t2);
    int t1;
    bus_wr(4'h8, KA, t1);
    bus_wr(4'hC, KB, t2);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #800000;
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int e, t;
    idle(3);
    // R1: state during and after hard reset
    check(rst_req == 1'b0, "R1 rst_req low in reset", rst_req, 0);
    rst_n = 1'b1;
    idle(2);
    rd_chk(4'h4, 32'h0, "R1 config after reset");
    rd_chk(4'h8, 32'h0, "R1 cause hard after reset");

    // R7: bit0 clear does nothing, bit0 set resets with code 3
    bus_wr(4'h0, 32'h0000_0002, e);
    idle(5);
    rd_chk(4'h8, 32'h0, "R7 zero write no effect");
    expect_rst(cyc + 1, "R7 soft reset latency");
    bus_wr(4'h0, 32'h1, e);
    drain();
    rd_chk(4'h8, 32'h3, "R7 cause soft");

    // R3: timeout delay 2 -> 8 cycles, re-enable does not restart
    expect_rst(cyc + 1 + 8, "R3 timeout delay2");
    bus_wr(4'h4, 32'h8000_0002, e);
    idle(2);
    bus_wr(4'h4, 32'h8000_0002, t);
    drain();
    rd_chk(4'h8, 32'h1, "R3 cause timeout");
    rd_chk(4'h4, 32'h0, "R9 config cleared by request");

    // R2 / R4: junk bits ignored, valid services keep it alive
    bus_wr(4'h4, 32'h8FF0_00E3, e);
    rd_chk(4'h4, 32'h8000_0003, "R2 config fields");
    rd_chk(4'h6, 32'h0, "R2 misaligned read");
    for (int i = 0; i < 5; i++) begin
      idle(6);
      service(t);
    end
    expect_rst(t + 16, "R4 window restarts at service");
    drain();
    rd_chk(4'h8, 32'h1, "R4 timeout after last service");

    // R5: wrong first key
    bus_wr(4'h4, 32'h8000_0003, e);
    expect_rst(cyc + 1, "R5 wrong first key");
    bus_wr(4'h8, 32'hABCD_1235, e);
    drain();
    rd_chk(4'h8, 32'h2, "R5 cause bad service");

    // R8: user pin held high gives one pulse
    expect_rst(cyc + 1, "R8 user edge");
    user_rst = 1'b1;
    idle(4);
    user_rst = 1'b0;
    drain();
    rd_chk(4'h8, 32'h4, "R8 cause user");

    // R5: second key without first
    bus_wr(4'h4, 32'h8000_0003, e);
    expect_rst(cyc + 1, "R5 wrong order");
    bus_wr(4'hC, KB, e);
    drain();
    rd_chk(4'h8, 32'h2, "R5 cause order");

    // R5: intervening write breaks the sequence
    bus_wr(4'h4, 32'h8000_0003, e);
    bus_wr(4'h8, KA, e);
    expect_rst(cyc + 2, "R5 intervening write");
    bus_wr(4'h4, 32'h8000_0003, e);
    bus_wr(4'hC, KB, e);
    drain();

    // R5: bad stores while disabled are ignored
    bus_wr(4'h8, 32'h1111_1111, e);
    bus_wr(4'hC, 32'h2222_2222, e);
    idle(20);
    rd_chk(4'h8, 32'h2, "R5 disabled bad store ignored");

    // R6: disable without service keeps running
    bus_wr(4'h4, 32'h8000_0003, e);
    expect_rst(e + 16, "R6 disable pending still times out");
    bus_wr(4'h4, 32'h0000_0003, t);
    rd_chk(4'h4, 32'h8000_0003, "R6 still enabled after clear");
    drain();
    rd_chk(4'h8, 32'h1, "R6 cause timeout");

    // R6: disable completes on valid service
    bus_wr(4'h4, 32'h8000_0003, e);
    bus_wr(4'h4, 32'h0000_0003, t);
    service(t);
    idle(40);
    rd_chk(4'h4, 32'h0000_0003, "R6 stopped after service");

    // R10: soft and user together -> code 3, one pulse
    expect_rst(cyc + 1, "R10 soft+user one pulse");
    user_rst = 1'b1;
    bus_wr(4'h0, 32'h1, e);
    user_rst = 1'b0;
    drain();
    rd_chk(4'h8, 32'h3, "R10 soft beats user");

    // R10: bad service and timeout on the same edge -> code 2
    bus_wr(4'h4, 32'h8000_0000, e);
    expect_rst(e + 2, "R10 bad+timeout one pulse");
    bus_wr(4'h8, KA, t);
    bus_wr(4'h8, 32'h0, t);
    drain();
    rd_chk(4'h8, 32'h2, "R10 bad beats timeout");

    // R9: request clears config but keeps cause
    bus_wr(4'h4, 32'h8000_0005, e);
    expect_rst(cyc + 1, "R9 soft while enabled");
    bus_wr(4'h0, 32'h1, e);
    drain();
    rd_chk(4'h4, 32'h0, "R9 config cleared");
    rd_chk(4'h8, 32'h3, "R9 cause kept");

    // R1: hard reset clears cause
    rst_n = 1'b0;
    idle(2);
    rd_chk(4'h8, 32'h0, "R1 hard reset cause");
    rst_n = 1'b1;
    idle(2);

    check(sb.size() == 0, "R9 missing pulses", sb.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule